// File: doc/BRIEF.md
# Fast GPIO Port Register Block

This block is a sixteen-pin general-purpose I/O port with a register file on a 32-bit local bus. Software writes a direction register and a pin-enable register, and loads output levels through a data register. Three write-only aliases change data bits without a read-modify-write: one sets bits, one clears bits and one inverts bits. Each register holds sixteen meaningful bits in the low halfword of a 32-bit slot. The bus may write a byte, a halfword or a word, and only the byte lanes whose strobe is high are updated.

On the pin side the block drives an output level and an output enable for every pin. It receives the raw pin levels and passes them through a two-flop synchronizer. A read of the data register, or of any of its aliases, returns a live port view. An enabled output pin returns its driven level. An enabled input pin returns its synchronized level. A disabled pin returns 0. Writes complete in one cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `fgpio_port`

## Requirements
- R1: After reset the direction, pin-enable and data registers are all zero. `pin_out`, `pin_oe` and `bus_rdata` are then zero.
- R2: The direction register is at index 0 (byte offset 0x00) and the pin-enable register is at index 1 (0x04). Both are read/write. `pin_oe[i]` is 1 exactly when enable bit i and direction bit i are both 1.
- R3: Writing the data register at index 2 (0x08) loads the strobed bits. `pin_out` shows the data register from the cycle after the write.
- R4: Byte strobe `bus_be[0]` covers bits 7:0 and `bus_be[1]` covers bits 15:8. Lanes with a low strobe keep their value. Strobes `bus_be[3:2]` and write bits 31:16 have no effect. Read bits 31:16 are always zero.
- R5: A write to the set alias at index 3 (0x0C) ORs the strobed write bits into the data register.
- R6: A write to the clear alias at index 4 (0x10) clears each data bit that is written as 0 in a strobed lane. Bits written as 1, and bits in unstrobed lanes, are unchanged.
- R7: A write to the toggle alias at index 5 (0x14) inverts each data bit whose strobed write bit is 1.
- R8: A read of index 2, 3, 4 or 5 returns the port view. For an enabled pin with direction 1 it returns the data bit. For an enabled pin with direction 0 it returns the synchronized input. A disabled pin returns 0.
- R9: Indices 6 and 7 (0x18, 0x1C) are unmapped. Writes to them change no register, and reads of them return zero.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is sampled high. It holds its value while no read is issued.
- R11: The synchronizer holds each pin change back by two clocks. A read captured at the third edge after the change is the first to show the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
Two paths can act on the same pin in one clock: an alias write to the data register, and a level change entering the input synchronizer. The bench provokes this on pin 8 while that pin is an enabled input. In the same cycle it issues a toggle write on that bit and flips the raw pin level. It then judges the two effects apart. Reads taken after the synchronizer delay must show only the new pin level. Once the direction is switched to output, the same read must show the toggled register bit, and `pin_out` must carry it throughout.

// File: rtl/fgpio_pkg.sv
package fgpio_pkg;

    localparam int NPINS      = 16;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 5;
    localparam int IDX_W      = ADDR_W - 2;
    localparam int PIN_LANES  = NPINS / 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [IDX_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_EN   = 3'd1,
        SEL_DATA = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_TOG  = 3'd5,
        SEL_GAP6 = 3'd6,
        SEL_GAP7 = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        reg_sel_e             sel;
        logic [PIN_LANES-1:0] be;
        logic [NPINS-1:0]     wdata;
    } bus_req_t;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] data;
    } port_state_t;

    // Expands byte strobes into a per-bit write mask over the pin-wide register.
    function automatic logic [NPINS-1:0] lane_mask(input logic [PIN_LANES-1:0] be);
        logic [NPINS-1:0] m;
        for (int l = 0; l < PIN_LANES; l++) begin
            m[l*8 +: 8] = {8{be[l]}};
        end
        return m;
    endfunction

    // True for the data register and its three aliases, which share the port view.
    function automatic logic is_data_view(input reg_sel_e s);
        return (s == SEL_DATA) || (s == SEL_SET) || (s == SEL_CLR) || (s == SEL_TOG);
    endfunction

endpackage

// File: rtl/fgpio_regs.sv
module fgpio_regs
    import fgpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_req_t    req,
    output port_state_t st
);

    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] wbits;

    assign wmask = lane_mask(req.be);
    assign wbits = req.wdata & wmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (req.wr) begin
            unique case (req.sel)
                SEL_DIR:  st.dir  <= (st.dir  & ~wmask) | wbits;
                SEL_EN:   st.en   <= (st.en   & ~wmask) | wbits;
                SEL_DATA: st.data <= (st.data & ~wmask) | wbits;
                SEL_SET:  st.data <= st.data | wbits;
                SEL_CLR:  st.data <= st.data & (req.wdata | ~wmask);
                SEL_TOG:  st.data <= st.data ^ wbits;
                default:  st      <= st;
            endcase
        end
    end

    assert_set_or_R5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_SET && (&req.be)) |=>
            st.data == ($past(st.data) | $past(req.wdata)));

    assert_clr_and_R6: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_CLR && (&req.be)) |=>
            st.data == ($past(st.data) & $past(req.wdata)));

    assert_tog_xor_R7: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_TOG && (&req.be)) |=>
            st.data == ($past(st.data) ^ $past(req.wdata)));

    assert_gap_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.sel == SEL_GAP6 || req.sel == SEL_GAP7)) |=> $stable(st));

    assert_lane_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_DATA && !req.be[0]) |=> $stable(st.data[7:0]));

endmodule

// File: rtl/fgpio_in_sync.sv
module fgpio_in_sync
    import fgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);

    logic [NPINS-1:0] stage [SYNC_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= raw;
    end

    for (genvar s = 1; s < SYNC_DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign synced = stage[SYNC_DEPTH-1];

    // Age counter so the delay check only looks back over post-reset cycles.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (age != 2) age <= age + 2'd1;
    end

    assert_sync_delay_R11: assert property (@(posedge clk) disable iff (rst)
        (age == 2) |-> synced == $past(raw, 2));

endmodule

// File: rtl/fgpio_readback.sv
module fgpio_readback
    import fgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  port_state_t      st,
    input  logic [NPINS-1:0] synced,
    output logic [BUS_W-1:0] rdata
);

    logic [NPINS-1:0] port_view;
    logic [NPINS-1:0] sel_val;

    assign port_view = st.en & ((st.dir & st.data) | (~st.dir & synced));

    always_comb begin
        sel_val = '0;
        if (req.sel == SEL_DIR)         sel_val = st.dir;
        else if (req.sel == SEL_EN)     sel_val = st.en;
        else if (is_data_view(req.sel)) sel_val = port_view;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= {{(BUS_W-NPINS){1'b0}}, sel_val};
    end

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(rdata));

    assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req.rd && is_data_view(req.sel)) |=> (rdata[NPINS-1:0] & ~$past(st.en)) == '0);

    assert_gap_read_R9: assert property (@(posedge clk) disable iff (rst)
        (req.rd && (req.sel == SEL_GAP6 || req.sel == SEL_GAP7)) |=> rdata == '0);

endmodule

// File: rtl/fgpio_port.sv
module fgpio_port
    import fgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    bus_req_t         req;
    port_state_t      st;
    logic [NPINS-1:0] synced;
    logic             unused_bus_bits;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = reg_sel_e'(bus_addr[ADDR_W-1:2]);
    assign req.be    = bus_be[PIN_LANES-1:0];
    assign req.wdata = bus_wdata[NPINS-1:0];

    assign unused_bus_bits = ^{bus_addr[1:0], bus_be[3:PIN_LANES], bus_wdata[BUS_W-1:NPINS]};

    fgpio_regs u_regs (
        .clk (clk),
        .rst (rst),
        .req (req),
        .st  (st)
    );

    fgpio_in_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (synced)
    );

    fgpio_readback u_rdback (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .st     (st),
        .synced (synced),
        .rdata  (bus_rdata)
    );

    assign pin_out = st.data;
    assign pin_oe  = st.en & st.dir;

    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == SEL_EN && (&req.be)) |=> (pin_oe & ~$past(req.wdata)) == '0);

    assert_out_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == SEL_DATA && (&req.be)) |=> pin_out == $past(req.wdata));

endmodule

// File: tb/test_fgpio_port.sv
`timescale 1ns/1ps
module test_fgpio_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    string       tagq [$];
    logic [31:0] expq [$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    fgpio_port i_fgpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        tagq.push_back(tag);
        expq.push_back(exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pops one expected item for every read the design sampled.
    always @(posedge clk) rd_seen <= bus_rd && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (expq.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
            end else begin
                chk(tagq.pop_front(), bus_rdata, expq.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        pin_in = 16'hAB00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        bus_read(5'h00, 32'h0, "R1 dir reset");
        bus_read(5'h08, 32'h0, "R1 data reset (pins disabled)");

        // R2: enable and direction, output enable gating
        bus_write(5'h04, 4'hF, 32'hFFFF_FFFF);
        chk("R2 oe with dir 0", {16'h0, pin_oe}, 32'h0);
        bus_write(5'h00, 4'hF, 32'h0000_00FF);
        chk("R2 oe", {16'h0, pin_oe}, 32'h0000_00FF);
        bus_read(5'h00, 32'h0000_00FF, "R2 dir readback");
        bus_read(5'h04, 32'h0000_FFFF, "R2/R4 en readback upper zero");

        // R10: rdata holds while idle
        repeat (2) @(negedge clk);
        chk("R10 rdata hold", bus_rdata, 32'h0000_FFFF);

        // R3 / R8: data write, mixed view
        bus_write(5'h08, 4'hF, 32'h0000_1234);
        chk("R3 pin_out", {16'h0, pin_out}, 32'h0000_1234);
        bus_read(5'h08, 32'h0000_AB34, "R8 mixed view");

        // R4: byte lanes
        bus_write(5'h08, 4'h2, 32'hFFFF_5678);
        chk("R4 upper lane only", {16'h0, pin_out}, 32'h0000_5634);
        bus_write(5'h08, 4'hC, 32'hFFFF_FFFF);
        chk("R4 high strobes inert", {16'h0, pin_out}, 32'h0000_5634);

        // R5 set, R6 clear, R7 toggle
        bus_write(5'h0C, 4'h3, 32'h0000_0003);
        chk("R5 set", {16'h0, pin_out}, 32'h0000_5637);
        bus_write(5'h10, 4'h3, 32'h0000_FFFE);
        chk("R6 clear bit0", {16'h0, pin_out}, 32'h0000_5636);
        bus_write(5'h10, 4'h2, 32'h0000_00FF);
        chk("R6 clear upper lane only", {16'h0, pin_out}, 32'h0000_0036);
        bus_write(5'h14, 4'h1, 32'h0000_00FF);
        chk("R7 toggle", {16'h0, pin_out}, 32'h0000_00C9);
        bus_read(5'h0C, 32'h0000_ABC9, "R8 set alias reads view");
        bus_read(5'h14, 32'h0000_ABC9, "R8 toggle alias reads view");

        // R9: unmapped
        bus_write(5'h18, 4'hF, 32'hFFFF_FFFF);
        bus_write(5'h1C, 4'hF, 32'hFFFF_FFFF);
        bus_read(5'h18, 32'h0, "R9 gap read");
        bus_read(5'h00, 32'h0000_00FF, "R9 dir untouched");
        chk("R9 data untouched", {16'h0, pin_out}, 32'h0000_00C9);

        // R8: disabled pins read zero
        bus_write(5'h04, 4'hF, 32'h0000_0F0F);
        chk("R2 oe partial enable", {16'h0, pin_oe}, 32'h0000_000F);
        bus_read(5'h08, 32'h0000_0B09, "R8 disabled pins zero");

        // R11: two-clock synchronizer delay
        pin_in = 16'h5500;
        bus_read(5'h08, 32'h0000_0B09, "R11 edge1 old");
        bus_read(5'h08, 32'h0000_0B09, "R11 edge2 old");
        bus_read(5'h08, 32'h0000_0509, "R11 edge3 new");

        // Same cycle: toggle write on input pin 8 while the pin flips
        pin_in = 16'h5400;
        bus_write(5'h14, 4'h2, 32'h0000_0100);
        chk("R7 toggle on input pin", {16'h0, pin_out}, 32'h0000_01C9);
        repeat (2) @(negedge clk);
        bus_read(5'h08, 32'h0000_0409, "R8 input pin shows pin not register");
        bus_write(5'h00, 4'hF, 32'h0000_FFFF);
        chk("R2 oe all out", {16'h0, pin_oe}, 32'h0000_0F0F);
        bus_read(5'h08, 32'h0000_0109, "R8 toggled bit visible as output");

        repeat (3) @(negedge clk);
        if (expq.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL scoreboard: actual %0d pending expected 0", expq.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule